// File: doc/BRIEF.md
# Counted Pseudo-DMA Byte Port

This block sits between a CPU byte bus and a SCSI controller that moves data through a counted buffer rather than through a real DMA engine. The controller arms a transfer with a length and a direction. When data flows to the host, the controller first loads the buffer through a fill port, and the CPU then drains it one byte per read of the data window. When data flows to the controller, the CPU writes bytes into the buffer. The controller sees nothing until the last byte arrives. At that point the whole buffer is handed over in one step with a commit pulse, and the controller reads it back through its own read port.

An offset counts the bytes moved. When the offset reaches the programmed size, the block raises a one-cycle done pulse toward the controller. CPU accesses that miss the data window go straight to the controller's register file. The register index is taken from the address shifted right by one bit, so the registers appear at every other byte address. The window match, the shift, the index width, the length width and the buffer depth are all parameters.

Top module: `pdma_byte_port`

## Requirements
- R1: An access whose address satisfies `(cpu_addr & 16'h8400) == 16'h8400` targets the data window. Any other access is passed to the register side as `reg_rd`/`reg_wr`, with `reg_idx = cpu_addr[4:1]`, `reg_wdata = cpu_wdata` and `cpu_rdata = reg_rdata`.
- R2: With `xfer_dir = 1` (to host), a data-window read made while the offset is below the size returns the buffer byte at the offset, in the same cycle, and advances the offset by one.
- R3: The read that moves the final byte raises `done` in the next clock cycle, and `done` stays high for exactly that one cycle.
- R4: With `xfer_dir = 0` (to controller), a data-window write made while the offset is below the size stores `cpu_wdata` at the offset and advances it. `commit` and `done` stay low until the final byte. In the cycle after the final byte, both pulse high for one cycle, and `ctl_rdata` then shows the collected bytes at `ctl_raddr` 0 to size-1.
- R5: A data-window read made when the offset is at or past the size returns 0, does not move the offset and raises no `done`.
- R6: A data-window write made when the offset is at or past the size is ignored. No buffer byte changes, and neither `done` nor `commit` pulses.
- R7: A data access against the armed direction is not counted. A read during a to-controller transfer returns 0. A write during a to-host transfer stores nothing and does not advance the offset.
- R8: `xfer_load` sets the offset to 0 and cancels any completion pending in that cycle. An access made in the same cycle as a load is not counted, and no `done` follows from it.
- R9: A length above the buffer depth (default 512) is clamped to the depth. With `xfer_len = 600`, `done` follows the 512th byte and not earlier.
- R10: `busy` is high exactly while the offset is below the size. A zero length leaves `busy` low and never produces `done`.
- R11: After reset, `busy`, `done` and `commit` are low.
- R12: `fill_we` writes `fill_data` at `fill_addr` in the buffer. When a fill and a CPU store fall in the same cycle, the fill takes the write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | CPU read byte (combinational) |
| reg_rd | output | 1 | Register read strobe to the controller |
| reg_wr | output | 1 | Register write strobe to the controller |
| reg_idx | output | 4 | Controller register index |
| reg_wdata | output | 8 | Controller register write byte |
| reg_rdata | input | 8 | Controller register read byte |
| xfer_load | input | 1 | Arms a new transfer |
| xfer_len | input | 16 | Requested transfer length in bytes |
| xfer_dir | input | 1 | 1 = to host, 0 = to controller |
| fill_we | input | 1 | Controller buffer write strobe |
| fill_addr | input | 9 | Controller buffer write address |
| fill_data | input | 8 | Controller buffer write byte |
| ctl_raddr | input | 9 | Controller buffer read address |
| ctl_rdata | output | 8 | Controller buffer read byte |
| commit | output | 1 | One-cycle pulse: write buffer complete |
| done | output | 1 | One-cycle pulse: count reached |
| busy | output | 1 | Offset below size |

## Verification
A wrong offset shows up at once in the next data-window read. That read returns the neighbouring byte, or 0, in the same cycle the access is made. A wrong size or a wrong compare shows up as a `done` pulse one byte early or late, or as a `busy` level that disagrees with the number of bytes moved so far. Write-side errors are hidden until commit. The stored bytes can only be seen through the controller read port, so the bench compares every collected byte after each commit, and also compares a guard byte after an ignored write.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

   typedef enum logic {
      DIR_TO_CTL  = 1'b0,
      DIR_TO_HOST = 1'b1
   } pdma_dir_e;

   function automatic int unsigned cnt_width(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/pdma_decode.sv
module pdma_decode #(
   parameter int unsigned        ADDR_W    = 16,
   parameter logic [ADDR_W-1:0]  WIN_MASK  = 16'h8400,
   parameter logic [ADDR_W-1:0]  WIN_MATCH = 16'h8400,
   parameter int unsigned        REG_SHIFT = 1,
   parameter int unsigned        IDX_W     = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   output logic              port_rd,
   output logic              port_wr,
   output logic              reg_rd,
   output logic              reg_wr,
   output logic [IDX_W-1:0]  reg_idx
);

   if (REG_SHIFT + IDX_W > ADDR_W) begin : g_bad_idx
      $error("register index does not fit in the address");
   end

   logic win_hit;

   assign win_hit = (addr & WIN_MASK) == WIN_MATCH;
   assign port_rd = rd & win_hit;
   assign port_wr = wr & win_hit;
   assign reg_rd  = rd & ~win_hit;
   assign reg_wr  = wr & ~win_hit;

   if (REG_SHIFT == 0) begin : g_direct
      assign reg_idx = addr[IDX_W-1:0];
   end else begin : g_shifted
      assign reg_idx = addr[REG_SHIFT +: IDX_W];
   end

endmodule

// File: rtl/pdma_buf.sv
module pdma_buf #(
   parameter int unsigned DEPTH = 512,
   parameter int unsigned DW    = 8,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [DW-1:0] rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [DW-1:0] rdata_b
);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/pdma_count.sv
module pdma_count
   import pdma_pkg::*;
#(
   parameter int unsigned DEPTH  = 512,
   parameter int unsigned LEN_W  = 16,
   localparam int unsigned OFF_W = cnt_width(DEPTH),
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] len,
   input  logic             dir,
   input  logic             port_rd,
   input  logic             port_wr,
   output logic             take_rd,
   output logic             take_wr,
   output logic [AW-1:0]    ptr,
   output logic             busy,
   output logic             done,
   output logic             commit
);

   if (LEN_W < OFF_W) begin : g_bad_len
      $error("length input narrower than the offset counter");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("buffer depth must be at least 2");
   end

   logic [OFF_W-1:0] off_q, size_q, size_c;
   pdma_dir_e        dir_q;
   logic             done_q, commit_q, last;

   assign size_c  = (len > LEN_W'(DEPTH)) ? OFF_W'(DEPTH) : len[OFF_W-1:0];
   assign busy    = off_q < size_q;
   assign take_rd = port_rd & busy & (dir_q == DIR_TO_HOST) & ~load;
   assign take_wr = port_wr & busy & (dir_q == DIR_TO_CTL) & ~load;
   assign last    = (take_rd | take_wr) && ((off_q + OFF_W'(1)) == size_q);
   assign ptr     = off_q[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q    <= '0;
         size_q   <= '0;
         dir_q    <= DIR_TO_HOST;
         done_q   <= 1'b0;
         commit_q <= 1'b0;
      end else if (load) begin
         off_q    <= '0;
         size_q   <= size_c;
         dir_q    <= pdma_dir_e'(dir);
         done_q   <= 1'b0;
         commit_q <= 1'b0;
      end else begin
         if (take_rd | take_wr) off_q <= off_q + OFF_W'(1);
         done_q   <= last;
         commit_q <= last & take_wr;
      end
   end

   assign done   = done_q;
   assign commit = commit_q;

   // R2
   off_le_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      off_q <= size_q);

   // R9
   size_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      size_q <= OFF_W'(DEPTH));

   // R3
   done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R4
   commit_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (done && dir_q == DIR_TO_CTL));

   // R6
   idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_wr && !busy && !load) |=> $stable(off_q));

   // R8
   load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (off_q == '0 && !done && !commit));

endmodule

// File: rtl/pdma_byte_port.sv
module pdma_byte_port
   import pdma_pkg::*;
#(
   parameter int unsigned        ADDR_W    = 16,
   parameter int unsigned        DEPTH     = 512,
   parameter int unsigned        LEN_W     = 16,
   parameter int unsigned        IDX_W     = 4,
   parameter int unsigned        REG_SHIFT = 1,
   parameter logic [ADDR_W-1:0]  WIN_MASK  = 16'h8400,
   parameter logic [ADDR_W-1:0]  WIN_MATCH = 16'h8400,
   localparam int unsigned       AW        = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [7:0]        cpu_wdata,
   output logic [7:0]        cpu_rdata,
   output logic              reg_rd,
   output logic              reg_wr,
   output logic [IDX_W-1:0]  reg_idx,
   output logic [7:0]        reg_wdata,
   input  logic [7:0]        reg_rdata,
   input  logic              xfer_load,
   input  logic [LEN_W-1:0]  xfer_len,
   input  logic              xfer_dir,
   input  logic              fill_we,
   input  logic [AW-1:0]     fill_addr,
   input  logic [7:0]        fill_data,
   input  logic [AW-1:0]     ctl_raddr,
   output logic [7:0]        ctl_rdata,
   output logic              commit,
   output logic              done,
   output logic              busy
);

   logic          port_rd, port_wr, take_rd, take_wr;
   logic [AW-1:0] ptr, buf_waddr;
   logic [7:0]    buf_wdata, buf_rbyte;
   logic          buf_we;

   pdma_decode #(
      .ADDR_W   (ADDR_W),
      .WIN_MASK (WIN_MASK),
      .WIN_MATCH(WIN_MATCH),
      .REG_SHIFT(REG_SHIFT),
      .IDX_W    (IDX_W)
   ) u_dec (
      .addr   (cpu_addr),
      .rd     (cpu_rd),
      .wr     (cpu_wr),
      .port_rd(port_rd),
      .port_wr(port_wr),
      .reg_rd (reg_rd),
      .reg_wr (reg_wr),
      .reg_idx(reg_idx)
   );

   pdma_count #(
      .DEPTH(DEPTH),
      .LEN_W(LEN_W)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (xfer_load),
      .len    (xfer_len),
      .dir    (xfer_dir),
      .port_rd(port_rd),
      .port_wr(port_wr),
      .take_rd(take_rd),
      .take_wr(take_wr),
      .ptr    (ptr),
      .busy   (busy),
      .done   (done),
      .commit (commit)
   );

   assign buf_we    = fill_we | take_wr;
   assign buf_waddr = fill_we ? fill_addr : ptr;
   assign buf_wdata = fill_we ? fill_data : cpu_wdata;

   pdma_buf #(
      .DEPTH(DEPTH),
      .DW   (8)
   ) u_buf (
      .clk    (clk),
      .we     (buf_we),
      .waddr  (buf_waddr),
      .wdata  (buf_wdata),
      .raddr_a(ptr),
      .rdata_a(buf_rbyte),
      .raddr_b(ctl_raddr),
      .rdata_b(ctl_rdata)
   );

   assign reg_wdata = cpu_wdata;

   always_comb begin
      if (port_rd) cpu_rdata = take_rd ? buf_rbyte : 8'h00;
      else         cpu_rdata = reg_rdata;
   end

   // R1
   reg_path_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_rd || port_wr) |-> !(reg_rd || reg_wr));

   // R5
   idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_rd && !busy) |-> (cpu_rdata == 8'h00));

endmodule

// File: tb/pdma_byte_port_test.sv
module pdma_byte_port_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_rdata;
   logic        reg_rd, reg_wr;
   logic [3:0]  reg_idx;
   logic [7:0]  reg_wdata, reg_rdata;
   logic        xfer_load = 1'b0;
   logic [15:0] xfer_len = '0;
   logic        xfer_dir = 1'b0;
   logic        fill_we = 1'b0;
   logic [8:0]  fill_addr = '0;
   logic [7:0]  fill_data = '0;
   logic [8:0]  ctl_raddr = '0;
   logic [7:0]  ctl_rdata;
   logic        commit, done, busy;

   int n_total = 0, n_fail = 0;
   logic [7:0] g_rd;
   logic       g_reg, g_done, g_commit, g_busy;
   logic [3:0] g_idx;

   always #5 clk = ~clk;

   assign reg_rdata = {4'hA, reg_idx};

   pdma_byte_port uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .xfer_load(xfer_load), .xfer_len(xfer_len), .xfer_dir(xfer_dir),
      .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data),
      .ctl_raddr(ctl_raddr), .ctl_rdata(ctl_rdata),
      .commit(commit), .done(done), .busy(busy)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic acc(input logic wr, input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_rd = !wr; cpu_wr = wr; cpu_wdata = d;
      #1;
      g_rd = cpu_rdata; g_reg = wr ? reg_wr : reg_rd; g_idx = reg_idx;
      @(negedge clk);
      cpu_rd = 1'b0; cpu_wr = 1'b0;
      #1;
      g_done = done; g_commit = commit; g_busy = busy;
   endtask

   task automatic arm(input logic [15:0] len, input logic dir);
      @(negedge clk);
      xfer_load = 1'b1; xfer_len = len; xfer_dir = dir;
      @(negedge clk);
      xfer_load = 1'b0;
   endtask

   task automatic fill(input logic [8:0] a, input logic [7:0] d);
      @(negedge clk);
      fill_we = 1'b1; fill_addr = a; fill_data = d;
      @(negedge clk);
      fill_we = 1'b0;
   endtask

   // {is_wr, addr, wdata, exp_rdata, exp_reg, exp_idx, exp_done}
   localparam logic [38:0] VEC [8] = '{
      {1'b0, 16'h8400, 8'h00, 8'h11, 1'b0, 4'h0, 1'b0},
      {1'b0, 16'h0006, 8'h00, 8'hA3, 1'b1, 4'h3, 1'b0},
      {1'b0, 16'h8C01, 8'h00, 8'h22, 1'b0, 4'h0, 1'b0},
      {1'b1, 16'h000A, 8'h5A, 8'h00, 1'b1, 4'h5, 1'b0},
      {1'b0, 16'h8000, 8'h00, 8'hA0, 1'b1, 4'h0, 1'b0},
      {1'b0, 16'h8401, 8'h00, 8'h33, 1'b0, 4'h0, 1'b1},
      {1'b0, 16'h8400, 8'h00, 8'h00, 1'b0, 4'h0, 1'b0},
      {1'b0, 16'h001E, 8'h00, 8'hAF, 1'b1, 4'hF, 1'b0}
   };

   initial begin
      repeat (100000) @(posedge clk);
      n_total++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 busy", busy, 0);
      chk("R11 done", done, 0);
      chk("R11 commit", commit, 0);
      rst_n = 1'b1;

      // table: to-host transfer of three bytes mixed with register accesses
      fill(9'd0, 8'h11); fill(9'd1, 8'h22); fill(9'd2, 8'h33);
      arm(16'd3, 1'b1);
      chk("R10 busy after arm", busy, 1);
      for (int i = 0; i < 8; i++) begin
         logic [38:0] v;
         v = VEC[i];
         acc(v[38], v[37:22], v[21:14]);
         if (!v[38]) chk($sformatf("R1/R2/R5 vec%0d rdata", i), g_rd, v[13:6]);
         chk($sformatf("R1 vec%0d reg strobe", i), g_reg, v[5]);
         if (v[5]) chk($sformatf("R1 vec%0d reg idx", i), g_idx, v[4:1]);
         chk($sformatf("R3 vec%0d done", i), g_done, v[0]);
         if (i == 5) begin
            @(negedge clk); #1;
            chk("R3 done single cycle", done, 0);
            chk("R10 busy after last", busy, 0);
         end
      end

      // R4 R6 R7 R12: to-controller transfer
      fill(9'd3, 8'hEE);
      arm(16'd3, 1'b0);
      acc(1'b1, 16'h8400, 8'hAA);
      chk("R4 no commit early", g_commit, 0);
      acc(1'b1, 16'h8400, 8'hBB);
      chk("R4 no done early", g_done, 0);
      acc(1'b0, 16'h8400, 8'h00);
      chk("R7 read against dir", g_rd, 8'h00);
      acc(1'b1, 16'h8400, 8'hCC);
      chk("R4 done", g_done, 1);
      chk("R4 commit", g_commit, 1);
      @(negedge clk); #1;
      chk("R4 commit single", commit, 0);
      for (int k = 0; k < 3; k++) begin
         ctl_raddr = 9'(k); #1;
         chk($sformatf("R4 byte %0d", k), ctl_rdata, 8'hAA + 8'(k) * 8'h11);
      end
      acc(1'b1, 16'h8400, 8'h77);
      chk("R6 no done", g_done, 0);
      chk("R6 no commit", g_commit, 0);
      ctl_raddr = 9'd3; #1;
      chk("R6 guard byte", ctl_rdata, 8'hEE);

      // R7 write against direction, R8 reload
      fill(9'd0, 8'h44); fill(9'd1, 8'h55);
      arm(16'd2, 1'b1);
      acc(1'b1, 16'h8400, 8'h99);
      ctl_raddr = 9'd0; #1;
      chk("R7 write not stored", ctl_rdata, 8'h44);
      acc(1'b0, 16'h8400, 8'h00);
      chk("R7 offset not moved", g_rd, 8'h44);
      arm(16'd2, 1'b1);
      acc(1'b0, 16'h8400, 8'h00);
      chk("R8 reload restarts", g_rd, 8'h44);
      // R8 load in the same cycle as the final read
      @(negedge clk);
      cpu_addr = 16'h8400; cpu_rd = 1'b1;
      xfer_load = 1'b1; xfer_len = 16'd2; xfer_dir = 1'b1;
      @(negedge clk);
      cpu_rd = 1'b0; xfer_load = 1'b0;
      #1;
      chk("R8 no done on load", done, 0);
      chk("R8 busy after load", busy, 1);
      acc(1'b0, 16'h8400, 8'h00);
      chk("R8 offset cleared", g_rd, 8'h44);

      // R12 fill priority over a CPU store
      arm(16'd2, 1'b0);
      @(negedge clk);
      cpu_addr = 16'h8400; cpu_wr = 1'b1; cpu_wdata = 8'h12;
      fill_we = 1'b1; fill_addr = 9'd0; fill_data = 8'h34;
      @(negedge clk);
      cpu_wr = 1'b0; fill_we = 1'b0;
      ctl_raddr = 9'd0; #1;
      chk("R12 fill wins", ctl_rdata, 8'h34);

      // R10 zero length
      arm(16'd0, 1'b1);
      chk("R10 zero busy", busy, 0);
      acc(1'b0, 16'h8400, 8'h00);
      chk("R10 zero read", g_rd, 8'h00);
      chk("R10 zero done", g_done, 0);

      // R9 clamp
      for (int k = 0; k < 512; k++) fill(9'(k), 8'(k) ^ 8'h5A);
      arm(16'd600, 1'b1);
      begin
         int errs;
         errs = 0;
         for (int k = 0; k < 511; k++) begin
            acc(1'b0, 16'h8400, 8'h00);
            if (g_rd !== (8'(k) ^ 8'h5A) || g_done !== 1'b0) errs++;
         end
         chk("R9 early bytes", errs, 0);
      end
      chk("R9 busy before last", g_busy, 1);
      acc(1'b0, 16'h8400, 8'h00);
      chk("R9 last byte", g_rd, 8'hFF ^ 8'h5A);
      chk("R9 done at depth", g_done, 1);

      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

endmodule